// File: doc/BRIEF.md
# Message-Signalled Interrupt Priority Queue Controller

This block sits beside one processor core and receives interrupt messages that a peripheral has written onto the core's response bus. Each message carries four fields: the requester's bus/device/function, a cause code, a priority, and a target core number. All four arrive in the bus address word. The bus data word is opaque to the block and travels alongside the message without being interpreted. The block keeps a message only when its target is this core's own number or the broadcast number. It then files the message into a first-in-first-out queue chosen by its priority, with one queue for each priority value.

On the consumer side, one stream interface offers the complete stored message, both address and data words. Normally it offers the oldest entry of the most urgent non-empty queue. A free-running phase counter flips that choice for one cycle in every period, so that the least urgent non-empty queue is served and low levels cannot starve. If a message arrives for a queue that is already full, it is lost, and a sticky fault flag records the loss until software clears it.

Top module: `msi_prio_irq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after release, `out_valid` and `ovf_err` are both 0.
- R2: The capture word is laid out as follows: bits [5:0] hold the target, [13:6] the cause, [16:14] the priority, and [32:17] the bus/device/function (bus in [32:25], device in [24:20], function in [19:17]). A strobed message is stored when its target equals `core_id` or equals 63 (all ones).
- R3: A strobed message whose target is neither `core_id` nor 63 is discarded and never appears on the output.
- R4: Outside the inverted cycle, the output offers the head of the non-empty queue with the numerically largest priority. Priority 7 is the most urgent.
- R5: Messages of the same priority leave in the order in which they were accepted.
- R6: A message leaves only on a rising edge where both `out_valid` and `out_ready` are 1. `out_ready` may be held low for any number of cycles, and `out_valid` does not depend on it.
- R7: A 6-bit phase counter starts at 0 on reset and advances on every clock edge. In the cycle where it reads 63 (the cycle after the 63rd, 127th, ... edge following release), the output offers the head of the non-empty queue with the smallest priority.
- R8: If every queue is empty during the inverted cycle, `out_valid` is 0 and nothing is removed.
- R9: Each queue holds 16 messages. A message accepted while its queue already holds 16 is dropped, even if that queue is popped in the same cycle. The 16 stored entries are unchanged.
- R10: A dropped message sets `ovf_err`. The flag stays set until an edge where `ovf_clr` is 1. If a drop and `ovf_clr` happen on the same edge, the flag is set.
- R11: `out_data` presents exactly the data word captured with the offered message, and `out_addr` presents exactly its capture word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id | input | 6 | This core's number, compared with the message target |
| cap_valid | input | 1 | Capture strobe for a message write on the response bus |
| cap_addr | input | 33 | Message fields in the layout given in R2 |
| cap_data | input | 32 | Opaque data word passed through with the message |
| out_valid | output | 1 | A pending message is offered |
| out_ready | input | 1 | Consumer accepts the offered message this cycle |
| out_addr | output | 33 | Capture word of the offered message |
| out_data | output | 32 | Data word of the offered message |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| ovf_err | output | 1 | Sticky flag: a message was dropped on a full queue |

## Verification
The inverted cycle is the hardest behaviour to reach. It lasts one cycle in 64, and it only shows a difference when at least two priority levels are pending at that moment. The stimulus fills all eight levels with back-pressure held on and then idles past several phase wraps. A cycle-accurate model in the bench tracks the phase from reset, so every sampled cycle is checked, inverted or not. The full-queue drop is reached by aiming 17 messages at one level. The drop is then repeated on the same edge as a clear pulse.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;
  localparam int PRIO_W  = 3;
  localparam int CAUSE_W = 8;
  localparam int TGT_W   = 6;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int BDF_W   = BUS_W + DEV_W + FN_W;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = BDF_W + PRIO_W + CAUSE_W + TGT_W;
  localparam int NQ      = 1 << PRIO_W;
  localparam logic [TGT_W-1:0] BCAST_TGT = {TGT_W{1'b1}};

  // Field order from MSB to LSB matches the capture word layout.
  typedef struct packed {
    logic [BDF_W-1:0]   bdf;
    logic [PRIO_W-1:0]  prio;
    logic [CAUSE_W-1:0] cause;
    logic [TGT_W-1:0]   target;
  } irq_msg_t;
endpackage

// File: rtl/msi_pq_fifo.sv
module msi_pq_fifo #(
  parameter int W     = 65,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (occ == CW'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      occ <= occ + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/msi_pq_arbiter.sv
module msi_pq_arbiter #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  nonempty,
  input  logic          invert,
  output logic          any,
  output logic [IW-1:0] sel
);
  logic [IW-1:0] top_idx, bot_idx;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++)
      if (nonempty[i]) top_idx = IW'(i);
    bot_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (nonempty[i]) bot_idx = IW'(i);
  end

  assign any = |nonempty;
  assign sel = invert ? bot_idx : top_idx;
endmodule

// File: rtl/msi_pq_phase.sv
module msi_pq_phase #(
  parameter int PERIOD = 64,
  localparam int CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic invert
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))  cnt <= '0;
    else                              cnt <= cnt + CW'(1);
  end

  assign invert = (cnt == CW'(PERIOD - 1));
endmodule

// File: rtl/msi_prio_irq_ctrl.sv
module msi_prio_irq_ctrl
  import msi_pq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int INV_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TGT_W-1:0]  core_id,
  input  logic              cap_valid,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              ovf_clr,
  output logic              ovf_err
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int ENT_W = ADDR_W + DATA_W;
  localparam int IW    = $clog2(NQ);

  irq_msg_t          cap_msg;
  logic              tgt_hit, take;
  logic [NQ-1:0]     q_ne, q_full, q_push, q_pop;
  logic [NQ-1:0][CW-1:0] q_occ;
  logic [ENT_W-1:0]  q_head [NQ];
  logic [IW-1:0]     sel;
  logic              inv_phase;
  logic              drop;

  assign cap_msg = irq_msg_t'(cap_addr);
  assign tgt_hit = (cap_msg.target == core_id) || (cap_msg.target == BCAST_TGT);
  assign take    = cap_valid && tgt_hit;

  msi_pq_phase #(.PERIOD(INV_PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .invert(inv_phase)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic q_empty;
    assign q_push[q] = take && (cap_msg.prio == PRIO_W'(q));
    assign q_pop[q]  = out_valid && out_ready && (sel == IW'(q));
    assign q_ne[q]   = !q_empty;

    msi_pq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[q]), .din({cap_addr, cap_data}),
      .pop(q_pop[q]), .head(q_head[q]),
      .empty(q_empty), .full(q_full[q]), .occ(q_occ[q])
    );
  end

  msi_pq_arbiter #(.N(NQ)) u_arb (
    .nonempty(q_ne), .invert(inv_phase), .any(out_valid), .sel(sel)
  );

  assign {out_addr, out_data} = q_head[sel];

  assign drop = |(q_push & q_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_err <= 1'b0;
    else if (drop)    ovf_err <= 1'b1;
    else if (ovf_clr) ovf_err <= 1'b0;
  end
endmodule

// File: rtl/msi_prio_irq_ctrl_chk.sv
module msi_prio_irq_ctrl_chk
  import msi_pq_pkg::*;
#(
  parameter int NQ_P = 8,
  parameter int CW   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [TGT_W-1:0]        core_id,
  input logic                    cap_valid,
  input logic [ADDR_W-1:0]       cap_addr,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [ADDR_W-1:0]       out_addr,
  input logic                    ovf_clr,
  input logic                    ovf_err,
  input logic                    inv_phase,
  input logic [NQ_P-1:0]         q_ne,
  input logic [NQ_P-1:0]         q_full,
  input logic [NQ_P-1:0][CW-1:0] q_occ
);
  irq_msg_t   in_m, out_m;
  logic       hit;
  int         total;
  logic [NQ_P-1:0] below_m, above_m;

  assign in_m  = irq_msg_t'(cap_addr);
  assign out_m = irq_msg_t'(out_addr);
  assign hit   = (in_m.target == core_id) || (&in_m.target);

  always_comb begin
    total = 0;
    for (int i = 0; i < NQ_P; i++) begin
      total += int'(q_occ[i]);
      below_m[i] = (i < int'(out_m.prio));
      above_m[i] = (i > int'(out_m.prio));
    end
  end

  a_r3_reject_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && !hit && !(out_valid && out_ready) |=> total == $past(total));

  a_r4_valid_tracks_queues: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (total != 0));

  a_r4_head_from_live_queue: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> q_ne[out_m.prio]);

  a_r4_none_more_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !inv_phase |-> (q_ne & above_m) == '0);

  a_r7_none_less_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && inv_phase |-> (q_ne & below_m) == '0);

  a_r10_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && hit && q_full[in_m.prio] |=> ovf_err);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !ovf_clr |=> ovf_err);
endmodule

bind msi_prio_irq_ctrl msi_prio_irq_ctrl_chk #(.NQ_P(NQ), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_id(core_id), .cap_valid(cap_valid),
  .cap_addr(cap_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .ovf_clr(ovf_clr), .ovf_err(ovf_err),
  .inv_phase(inv_phase), .q_ne(q_ne), .q_full(q_full), .q_occ(q_occ)
);

// File: tb/msi_prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module msi_prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  core_id = '0;
  logic        cap_valid = 1'b0;
  logic [32:0] cap_addr = '0;
  logic [31:0] cap_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [32:0] out_addr;
  logic [31:0] out_data;
  logic        ovf_clr = 1'b0;
  logic        ovf_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_prio_irq_ctrl u_msi_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .core_id(core_id), .cap_valid(cap_valid),
    .cap_addr(cap_addr), .cap_data(cap_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
    .ovf_clr(ovf_clr), .ovf_err(ovf_err)
  );

  // Reference model built from the requirements.
  logic [64:0] mq [8][16];
  int          mn [8];
  logic        merr;
  longint      ec;

  function automatic bit inv_now();
    return (ec % 64) == 63;
  endfunction

  function automatic int pick(input bit inv);
    int p = -1;
    if (inv) begin
      for (int i = 7; i >= 0; i--) if (mn[i] != 0) p = i;
    end else begin
      for (int i = 0; i < 8; i++) if (mn[i] != 0) p = i;
    end
    return p;
  endfunction

  function automatic logic [32:0] mk(input logic [15:0] bdf, input logic [2:0] pr,
                                     input logic [7:0] cs, input logic [5:0] tg);
    return {bdf, pr, cs, tg};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mn[i] = 0;
      merr = 1'b0;
      ec = 0;
    end else begin
      int p;
      bit was_full;
      int pr;
      pr = int'(cap_addr[16:14]);
      was_full = (mn[pr] == 16);
      p = pick(inv_now());
      if (p >= 0 && out_ready) begin
        for (int i = 0; i < 15; i++) mq[p][i] = mq[p][i+1];
        mn[p]--;
      end
      if (cap_valid && (cap_addr[5:0] == core_id || cap_addr[5:0] == 6'h3F)) begin
        if (was_full) merr = 1'b1;
        else begin
          mq[pr][mn[pr]] = {cap_addr, cap_data};
          mn[pr]++;
        end
        if (!was_full && ovf_clr) merr = 1'b0;
      end else if (ovf_clr) merr = 1'b0;
      ec++;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p;
      string t;
      p = pick(inv_now());
      t = inv_now() ? "R7" : "R4";
      check(t, longint'(out_valid), longint'(p >= 0));
      if (p >= 0 && out_valid) begin
        check("R5 R11 addr", longint'(out_addr), longint'(mq[p][0][64:32]));
        check("R11 data", longint'(out_data), longint'(mq[p][0][31:0]));
      end
      check("R10", longint'(ovf_err), longint'(merr));
    end
  end

  function automatic int model_total();
    int s = 0;
    for (int i = 0; i < 8; i++) s += mn[i];
    return s;
  endfunction

  task automatic drain(input int mode, output int popped);
    popped = 0;
    for (int i = 0; i < 400; i++) begin
      if (model_total() == 0) break;
      out_ready = (mode == 0) ? 1'b1 : ((i % 3) != 0);
      @(posedge clk);
      if (out_valid && out_ready) popped++;
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  initial begin
    int popped;
    int cids [3] = '{0, 21, 62};
    repeat (3) @(negedge clk);
    check("R1 valid in reset", longint'(out_valid), 0);
    check("R1 flag in reset", longint'(ovf_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", longint'(out_valid), 0);
    check("R1 flag after release", longint'(ovf_err), 0);

    // Target sweep: all 64 targets for several core numbers (R2, R3, R6).
    foreach (cids[c]) begin
      core_id = 6'(cids[c]);
      for (int t = 0; t < 64; t++) begin
        cap_valid = 1'b1;
        cap_addr  = mk(16'(cids[c] * 256 + t), 3'(t % 8), 8'(t ^ 8'h5A), 6'(t));
        cap_data  = 32'hC0DE_0000 | 32'(cids[c] << 8) | 32'(t);
        @(negedge clk);
      end
      cap_valid = 1'b0;
      check("R2 R3 stored count", longint'(model_total()), 2);
      drain(0, popped);
      check("R2 R3 delivered count", longint'(popped), 2);
    end

    // Mixed priorities, held across inversion cycles, then gated drain (R4 R5 R6 R7).
    core_id = 6'd9;
    for (int k = 0; k < 24; k++) begin
      cap_valid = 1'b1;
      cap_addr  = mk(16'(k), 3'((k * 5) % 8), 8'(k), (k % 2) ? 6'h3F : 6'd9);
      cap_data  = 32'(k) * 32'h0101_0101;
      @(negedge clk);
    end
    cap_valid = 1'b0;
    for (int i = 0; i < 140; i++) begin
      if (inv_now()) check("R7 lowest level offered", longint'(out_addr[16:14]), 0);
      else           check("R4 top level offered", longint'(out_addr[16:14]), 7);
      @(negedge clk);
    end
    drain(1, popped);
    check("R6 R5 mixed delivered", longint'(popped), 24);

    // Overflow on level 2 (R9 R10).
    for (int k = 0; k < 17; k++) begin
      cap_valid = 1'b1;
      cap_addr  = mk(16'h2000 + 16'(k), 3'd2, 8'hEE, 6'd9);
      cap_data  = 32'hF000_0000 + 32'(k);
      @(negedge clk);
    end
    cap_valid = 1'b0;
    check("R10 flag set on drop", longint'(ovf_err), 1);
    repeat (3) @(negedge clk);
    check("R10 flag holds", longint'(ovf_err), 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R10 flag cleared", longint'(ovf_err), 0);
    cap_valid = 1'b1;
    ovf_clr   = 1'b1;
    cap_addr  = mk(16'h2FFF, 3'd2, 8'hEE, 6'h3F);
    cap_data  = 32'hDEAD_BEEF;
    @(negedge clk);
    cap_valid = 1'b0;
    ovf_clr   = 1'b0;
    check("R10 set wins over clear", longint'(ovf_err), 1);
    drain(0, popped);
    check("R9 only 16 kept", longint'(popped), 16);

    // Empty queues across inversion cycles (R8).
    out_ready = 1'b1;
    for (int i = 0; i < 130; i++) begin
      if (inv_now()) check("R8 empty inversion", longint'(out_valid), 0);
      @(negedge clk);
    end
    out_ready = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule